// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus interface state machine for a processor core whose external bus carries a 20-bit address and 8-bit data, with the low address byte sharing pins with the data. The core hands over one request at a time: a three-bit cycle code, the address, write data, the segment in use and the interrupt-enable flag. The sequencer then runs a T1, T2, T3, any number of wait states (Tw), T4 cycle. It generates the address latch pulse, the read, write and interrupt-acknowledge strobes, the transceiver enable and direction, the cycle-type status lines and the output enables for every bus pin group. It returns the byte read and a one-clock done pulse.

The design runs on one rising-edge clock at twice the bus-state rate. A phase bit splits every T-state into a first half (phase 0) and a second half (phase 1), so that the mid-state strobe edges fall on ordinary clock edges. When another master raises `hold`, the sequencer grants the bus at the middle of a T4 or idle state. It then floats everything except the latch pulse until `hold` drops again.

Top module: `mux_bus_sequencer`

## Requirements
- R1: A synchronous active-high `rst` returns the sequencer to idle. In idle, `rd_n`, `wr_n`, `inta_n` and `den_n` are 1, `ale`, `done` and `hlda` are 0, and {`io_m`,`dt_r`,`sso`} shows the passive code 011.
- R2: `ale` is 1 for exactly the second half of T1 and 0 at all other times. `ad_oe` is 1 throughout T1, and `ad_out` then carries address bits 7..0.
- R3: `a_mid` carries address bits 15..8 and holds them unchanged from T1 through T4.
- R4: In T1, `a_top` carries address bits 19..16 when code bit 2 is 0, and is 0 when code bit 2 is 1. From T2 through T4, `a_top` is the status nibble {bit3 = 0, bit2 = interrupt-enable flag, bits1..0 = segment: 00 alternate, 01 stack, 10 code/none, 11 data}.
- R5: The strobes are active (0) from T2 through the last Tw. `rd_n` is active for codes 000, 001 and 101, `wr_n` for codes 010 and 110, and `inta_n` for code 100. Halt (111) asserts no strobe, and at most one strobe is ever active.
- R6: For read-type and interrupt-acknowledge codes, `den_n` is 0 from the second half of T2 to the end of the first half of T4. For write codes it is 0 from the start of T2 to the end of the first half of T4. For halt it stays 1.
- R7: {`io_m`,`dt_r`,`sso`} equals the request code from T1 through T4, with codes 100 interrupt ack, 101 I/O read, 110 I/O write, 111 halt, 000 code fetch, 001 memory read and 010 memory write. It is 011 when idle.
- R8: `ready` is sampled at the end of T3 and of each Tw. A 0 adds a Tw, and a 1 moves to T4 and captures `ad_in` into `rd_data`. `done` is 1 for the second half of T4.
- R9: For write codes, `ad_oe` stays 1 and `ad_out` carries the write data from T2 through T4. For all other codes, `ad_oe` is 0 from T2 onward.
- R10: With `hold` at 1, `hlda` rises at the middle of a T4 or idle state. While `hlda` is 1, `ad_oe` and `bus_oe` are 0 and no request is accepted. `hlda` falls on the first edge after `hold` returns to 0, and `bus_oe` returns to 1 at the same time.
- R11: `req_rdy` is 1 only in the second half of an idle state with no hold pending. A request is taken when `req_valid` and `req_rdy` are both 1, and T1 begins on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-state rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents a request |
| req_rdy | output | 1 | Sequencer can take a request this clock |
| req_code | input | 3 | Cycle code {IO/M, DT/R, SSO} |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_seg | input | 2 | Segment in use for status |
| req_ie | input | 1 | Interrupt-enable flag for status |
| done | output | 1 | Cycle finishing (second half of T4) |
| rd_data | output | 8 | Byte captured from the bus |
| ready | input | 1 | Synchronised ready from the target |
| hold | input | 1 | Another master requests the bus |
| hlda | output | 1 | Bus released |
| ad_out | output | 8 | Multiplexed address/data drive value |
| ad_in | input | 8 | Multiplexed address/data pin value |
| ad_oe | output | 1 | Output enable for the multiplexed lines |
| a_mid | output | 8 | Address bits 15..8 |
| a_top | output | 4 | Address bits 19..16, or status |
| bus_oe | output | 1 | Output enable for a_mid, a_top and control lines |
| ale | output | 1 | Address latch pulse (never floated) |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| io_m | output | 1 | 1 for I/O-class codes |
| dt_r | output | 1 | 1 for transmit |
| sso | output | 1 | Third status bit |

## Verification
The assertions take for granted that the passive code 011 is never requested. They also assume that `ready` and `hold` are stable around the rising edge, and that `req_valid` has effect only while `req_rdy` is 1. The bench drives every input at the falling edge and only offers the seven real cycle codes. It computes `ready` from a wait count per cycle, so a Tw is entered only where the table asks for one. It raises `hold` either in idle or part-way through a cycle. It then watches the grant land at mid-T4, with `done` still delivered and the data lines floated.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {ST_TI, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4} bus_st_t;

  localparam logic [2:0] CODE_PASSIVE = 3'b011;

  function automatic logic code_reads(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b001) || (c == 3'b101);
  endfunction

  function automatic logic code_writes(input logic [2:0] c);
    return (c == 3'b010) || (c == 3'b110);
  endfunction

  function automatic logic code_inta(input logic [2:0] c);
    return c == 3'b100;
  endfunction

  // T2, T3 and every wait state carry the strobe
  function automatic logic strobe_span(input bus_st_t st);
    return (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
  endfunction

  // transceiver window: writes open at T2 start, inbound cycles at mid-T2
  function automatic logic den_window(input logic [2:0] c, input bus_st_t st,
                                      input logic ph);
    logic body;
    body = (st == ST_T3) || (st == ST_TW) || (st == ST_T4 && !ph);
    if (code_writes(c))                    return body || (st == ST_T2);
    else if (code_reads(c) || code_inta(c)) return body || (st == ST_T2 && ph);
    else                                   return 1'b0;
  endfunction

  function automatic logic ad_drive(input logic [2:0] c, input bus_st_t st);
    return (st == ST_T1) ||
           (code_writes(c) && (strobe_span(st) || st == ST_T4));
  endfunction

  function automatic logic [3:0] status_nibble(input logic ie, input logic [1:0] seg);
    return {1'b0, ie, seg};
  endfunction

endpackage

// File: rtl/bcs_phase_fsm.sv
module bcs_phase_fsm
  import bcs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  logic    ready,
  input  logic    hold,
  output bus_st_t state,
  output logic    ph,
  output logic    hlda,
  output logic    req_rdy,
  output logic    accept,
  output logic    sample,
  output logic    done
);

  bus_st_t nxt;

  assign req_rdy = (state == ST_TI) && ph && !hold && !hlda;
  assign accept  = req_rdy && req_valid;
  assign sample  = ph && ready && ((state == ST_T3) || (state == ST_TW));
  assign done    = (state == ST_T4) && ph;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_TI:        if (accept) nxt = ST_T1;
      ST_T1:        nxt = ST_T2;
      ST_T2:        nxt = ST_T3;
      ST_T3, ST_TW: nxt = ready ? ST_T4 : ST_TW;
      ST_T4:        nxt = ST_TI;
      default:      nxt = ST_TI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_TI;
      ph    <= 1'b0;
      hlda  <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) state <= nxt;
      if (!hold)
        hlda <= 1'b0;
      else if (!ph && (state == ST_TI || state == ST_T4))
        hlda <= 1'b1;
    end
  end

  AST_WAIT_NEEDS_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TW && $past(state) != ST_TW) |-> !$past(ready)); // R8

  AST_HLDA_RISE_POINT: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> (($past(state) == ST_TI || $past(state) == ST_T4) && !$past(ph))); // R10

  AST_T1_AFTER_ACCEPT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T1 && $past(state) != ST_T1) |-> $past(req_valid)); // R11

endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_st_t    state,
  input  logic       ph,
  input  logic       hlda,
  input  logic [2:0] code,
  output logic       ale,
  output logic       rd_n,
  output logic       wr_n,
  output logic       inta_n,
  output logic       den_n,
  output logic       io_m,
  output logic       dt_r,
  output logic       sso,
  output logic       ad_oe,
  output logic       bus_oe
);

  logic       in_cycle;
  logic       span;
  logic [2:0] shown;

  assign in_cycle = (state != ST_TI);
  assign span     = strobe_span(state) && !hlda;
  assign shown    = in_cycle ? code : CODE_PASSIVE;

  assign ale    = (state == ST_T1) && ph;
  assign rd_n   = !(span && code_reads(code));
  assign wr_n   = !(span && code_writes(code));
  assign inta_n = !(span && code_inta(code));
  assign den_n  = !(den_window(code, state, ph) && !hlda);
  assign {io_m, dt_r, sso} = shown;
  assign ad_oe  = ad_drive(code, state) && !hlda;
  assign bus_oe = !hlda;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({~rd_n, ~wr_n, ~inta_n}) <= 1); // R5

  AST_ALE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> !ale); // R2

  AST_WRITE_UNDER_DEN: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> !den_n); // R6

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int MID_W = 16 - DATA_W,
  localparam int TOP_W = ADDR_W - 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              sample,
  input  bus_st_t           state,
  input  logic [2:0]        req_code,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_seg,
  input  logic              req_ie,
  input  logic [DATA_W-1:0] ad_in,
  output logic [2:0]        code,
  output logic [DATA_W-1:0] ad_out,
  output logic [MID_W-1:0]  a_mid,
  output logic [TOP_W-1:0]  a_top,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        seg_q;
  logic              ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code    <= CODE_PASSIVE;
      addr_q  <= '0;
      wdata_q <= '0;
      seg_q   <= '0;
      ie_q    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (accept) begin
        code    <= req_code;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        seg_q   <= req_seg;
        ie_q    <= req_ie;
      end
      if (sample) rd_data <= ad_in;
    end
  end

  assign ad_out = (state == ST_T1) ? addr_q[DATA_W-1:0] : wdata_q;
  assign a_mid  = addr_q[15:DATA_W];
  assign a_top  = (state == ST_T1) ? (code[2] ? '0 : addr_q[ADDR_W-1:16])
                                   : TOP_W'(status_nibble(ie_q, seg_q));

  AST_MID_HELD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_TI && $past(state) != ST_TI) |-> $stable(a_mid)); // R3

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int MID_W = 16 - DATA_W,
  localparam int TOP_W = ADDR_W - 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_rdy,
  input  logic [2:0]        req_code,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_seg,
  input  logic              req_ie,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda,
  output logic [DATA_W-1:0] ad_out,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ad_oe,
  output logic [MID_W-1:0]  a_mid,
  output logic [TOP_W-1:0]  a_top,
  output logic              bus_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  output logic              den_n,
  output logic              io_m,
  output logic              dt_r,
  output logic              sso
);

  bus_st_t    state;
  logic       ph;
  logic       accept;
  logic       sample;
  logic [2:0] code;

  bcs_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready), .hold(hold),
    .state(state), .ph(ph), .hlda(hlda), .req_rdy(req_rdy),
    .accept(accept), .sample(sample), .done(done)
  );

  bcs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .sample(sample), .state(state),
    .req_code(req_code), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_seg(req_seg), .req_ie(req_ie), .ad_in(ad_in),
    .code(code), .ad_out(ad_out), .a_mid(a_mid), .a_top(a_top),
    .rd_data(rd_data)
  );

  bcs_strobe_gen u_stb (
    .clk(clk), .rst(rst), .state(state), .ph(ph), .hlda(hlda), .code(code),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .den_n(den_n),
    .io_m(io_m), .dt_r(dt_r), .sso(sso), .ad_oe(ad_oe), .bus_oe(bus_oe)
  );

  AST_HOLD_FLOATS_BUS: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!ad_oe && !bus_oe && rd_n && wr_n && inta_n)); // R10

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

endmodule

// File: tb/tb_mux_bus_sequencer.sv
module tb_mux_bus_sequencer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_rdy;
  logic [2:0] req_code = 3'b001;
  logic [19:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [1:0] req_seg = '0;
  logic       req_ie = 1'b0;
  logic       done;
  logic [7:0] rd_data;
  logic       ready = 1'b1;
  logic       hold = 1'b0;
  logic       hlda;
  logic [7:0] ad_out;
  logic [7:0] ad_in = '0;
  logic       ad_oe;
  logic [7:0] a_mid;
  logic [3:0] a_top;
  logic       bus_oe, ale, rd_n, wr_n, inta_n, den_n, io_m, dt_r, sso;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  mux_bus_sequencer dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_rdy(req_rdy),
    .req_code(req_code), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_seg(req_seg), .req_ie(req_ie), .done(done), .rd_data(rd_data),
    .ready(ready), .hold(hold), .hlda(hlda), .ad_out(ad_out), .ad_in(ad_in),
    .ad_oe(ad_oe), .a_mid(a_mid), .a_top(a_top), .bus_oe(bus_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .den_n(den_n),
    .io_m(io_m), .dt_r(dt_r), .sso(sso)
  );

  // vector: code[43:41] addr[40:21] wdata[20:13] seg[12:11] ie[10] waits[9:8] rdval[7:0]
  localparam int NV = 8;
  localparam logic [43:0] VEC [0:NV-1] = '{
    {3'b001, 20'hA5C3E, 8'h00, 2'b11, 1'b1, 2'd0, 8'h5A},
    {3'b010, 20'h12F80, 8'hC3, 2'b00, 1'b0, 2'd1, 8'h00},
    {3'b101, 20'h003F8, 8'h00, 2'b10, 1'b1, 2'd2, 8'h96},
    {3'b110, 20'h00061, 8'h7E, 2'b01, 1'b0, 2'd0, 8'h00},
    {3'b000, 20'hFFFF0, 8'h00, 2'b10, 1'b0, 2'd3, 8'hEA},
    {3'b100, 20'h00000, 8'h00, 2'b10, 1'b1, 2'd1, 8'h08},
    {3'b111, 20'h0ABCD, 8'h00, 2'b10, 1'b1, 2'd0, 8'h00},
    {3'b001, 20'h80001, 8'h00, 2'b01, 1'b0, 2'd0, 8'h3C}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit is_rd(input logic [2:0] c);
    return c == 3'b000 || c == 3'b001 || c == 3'b101;
  endfunction
  function automatic bit is_wr(input logic [2:0] c);
    return c[1:0] == 2'b10;
  endfunction

  task automatic idle_check(input string tag);
    chk({tag, " strobes idle"}, {rd_n, wr_n, inta_n, den_n}, 4'hF);
    chk({tag, " ale low"}, ale, 1'b0);
    chk({tag, " code passive"}, {io_m, dt_r, sso}, 3'b011);
    chk({tag, " done low"}, done, 1'b0);
  endtask

  // Runs one bus cycle; hold_t >= 0 raises hold in that T-state (0 = T1)
  task automatic run_vec(input logic [43:0] v, input int hold_t);
    logic [2:0] c;
    logic [19:0] a;
    logic [7:0] wd, rv;
    logic [1:0] sg;
    logic ie;
    int w, nt, guard;
    bit act, den, hl;
    c = v[43:41]; a = v[40:21]; wd = v[20:13]; sg = v[12:11];
    ie = v[10]; w = int'(v[9:8]); rv = v[7:0];
    nt = 4 + w;
    guard = 0;
    while (!req_rdy && guard < 50) begin @(negedge clk); guard++; end
    chk("R11 req_rdy seen in idle", req_rdy, 1'b1);
    req_valid = 1'b1; req_code = c; req_addr = a; req_wdata = wd;
    req_seg = sg; req_ie = ie; ad_in = rv; ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < nt; t++) begin
      for (int h = 0; h < 2; h++) begin
        if (hold_t >= 0 && t == hold_t && h == 0) hold = 1'b1;
        ready = (t >= 2 + w);
        act = (t >= 1) && (t <= 2 + w);
        hl  = (hold_t >= 0) && (t == nt - 1) && (h == 1);
        if (is_wr(c))
          den = (t >= 1 && t <= 2 + w) || (t == nt - 1 && h == 0);
        else if (is_rd(c) || c == 3'b100)
          den = (t == 1 && h == 1) || (t >= 2 && t <= 2 + w) || (t == nt - 1 && h == 0);
        else
          den = 1'b0;
        chk("R11 req_rdy low in cycle", req_rdy, 1'b0);
        chk("R2 ale", ale, (t == 0 && h == 1));
        chk("R2/R9 ad_oe", ad_oe, !hl && (t == 0 || is_wr(c)));
        if (t == 0) chk("R2 low address", ad_out, a[7:0]);
        if (t >= 1 && is_wr(c)) chk("R9 write data", ad_out, wd);
        chk("R3 a_mid", a_mid, a[15:8]);
        if (t == 0) chk("R4 a_top address", a_top, c[2] ? 4'h0 : a[19:16]);
        else        chk("R4 a_top status", a_top, {1'b0, ie, sg});
        chk("R5 rd_n", rd_n, !(act && is_rd(c)));
        chk("R5 wr_n", wr_n, !(act && is_wr(c)));
        chk("R5 inta_n", inta_n, !(act && c == 3'b100));
        chk("R6 den_n", den_n, !den);
        chk("R7 status code", {io_m, dt_r, sso}, c);
        chk("R8 done", done, (t == nt - 1 && h == 1));
        if (t == nt - 1 && h == 1 && (is_rd(c) || c == 3'b100))
          chk("R8 rd_data", rd_data, rv);
        chk("R10 hlda", hlda, hl);
        chk("R10 bus_oe", bus_oe, !hl);
        @(negedge clk);
      end
    end
    ready = 1'b1;
    if (hold_t < 0) idle_check("R7 after cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1 in reset");
    chk("R1 hlda in reset", hlda, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], -1);

    // R10: hold in idle
    hold = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 hlda granted in idle", hlda, 1'b1);
    for (int k = 0; k < 6; k++) begin
      chk("R10 floated in hold", {bus_oe, ad_oe, ale}, 3'b000);
      chk("R10 no accept in hold", req_rdy, 1'b0);
      @(negedge clk);
    end
    hold = 1'b0;
    @(negedge clk);
    chk("R10 hlda released", hlda, 1'b0);
    chk("R10 bus driven again", bus_oe, 1'b1);
    run_vec(VEC[3], -1);

    // R10: hold raised in T2 is granted only at mid-T4
    run_vec(VEC[2], 1);
    chk("R10 hlda kept after cycle", hlda, 1'b1);
    chk("R10 no accept after grant", req_rdy, 1'b0);
    hold = 1'b0;
    @(negedge clk);
    chk("R10 hlda dropped", hlda, 1'b0);
    run_vec(VEC[0], -1);

    // R1: reset in the middle of a write cycle
    while (!req_rdy) @(negedge clk);
    req_valid = 1'b1; req_code = 3'b010; req_addr = 20'h54321; req_wdata = 8'hA5;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 write strobe before reset", wr_n, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    idle_check("R1 reset mid-cycle");
    chk("R1 ad released", ad_oe, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    run_vec(VEC[7], -1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule